// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Compressed Test Mode

This block models the control logic of a 1M x 4 multiplexed-address DRAM. It runs on a fast system clock, samples the four active-low strobes (row strobe, column strobe, write enable, output enable), and works out the cycle type from the order in which the strobes fall. A row strobe that falls while the column strobe is high opens the row on the address pins. The cycle that follows is either a column access (read, early write, read-modify-write or fast page) or, if no column strobe arrives, a refresh of that pin row only. A row strobe that falls while the column strobe is already low is a counter refresh, and the row comes from an internal 10-bit counter. If write enable is also low at that moment, the block enters a sticky test mode.

Every row strobe fall produces a one-clock refresh report that gives the refreshed row and how it was chosen. In test mode, writes fill both columns of an even/odd column pair. Reads return a per-bit match result for that pair instead of stored data. The cell store is a small parameterized register array indexed by the low address bits.

Top module: `dram_cycle_ctrl`

## Requirements
- R1: After reset, dout_en_o, dout_o, test_mode_o, ref_pulse_o and ref_kind_o are all 0, and the refresh counter holds 0.
- R2: A row strobe fall while the column strobe is high raises ref_pulse_o for one clock with ref_row_o equal to addr_i and ref_kind_o = 1. If no column strobe follows, dout_en_o stays 0 for the whole cycle.
- R3: A row strobe fall while the column strobe is low and write enable is high reports ref_kind_o = 2 with ref_row_o equal to the counter. The counter then advances by one and wraps from 1023 to 0. dout_en_o is never set during such a cycle.
- R4: A row strobe fall while both the column strobe and write enable are low reports ref_kind_o = 3, uses and advances the counter, and sets test_mode_o.
- R5: Test mode is cleared by a counter refresh, or by a pin-row cycle whose row strobe rises with no column strobe fall. Reads and writes during test mode leave it set, and each still reports its own row refresh.
- R6: A column strobe fall with write enable high and output enable low drives dout_en_o = 1, with dout_o equal to the word stored at the open row and the column on addr_i.
- R7: A column strobe fall with write enable low stores din_i at that word, and dout_en_o stays 0 for the rest of that column access.
- R8: When write enable falls while a read access is in progress, din_i is stored at the accessed word, and dout_o keeps showing the data read before the write.
- R9: dout_en_o returns to 0 one clock after the column strobe or output enable is sampled high.
- R10: In test mode a write stores din_i at both columns of the pair (column with LSB 0 and LSB 1). A read gives, for each bit, 1 when the two columns agree and 0 when they differ.
- R11: Several column strobe falls within one open row each write or read their own column.
- R12: dout_o is 0 whenever dout_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 10 | Multiplexed row/column address |
| din_i | input | 4 | Write data |
| dout_o | output | 4 | Read data (0 when not driven) |
| dout_en_o | output | 1 | Data-out driver enable |
| test_mode_o | output | 1 | Test mode flag |
| ref_pulse_o | output | 1 | One-clock report of a row refresh |
| ref_row_o | output | 10 | Row refreshed by the latest row strobe fall |
| ref_kind_o | output | 2 | 1 pin row, 2 counter refresh, 3 test entry |

## Verification
Every result is registered once. A strobe change sampled at one rising edge shows up on the outputs right after that edge: data, the enable, the refresh report and the test flag all take effect after exactly one clock. The bench changes inputs on the falling edge. Its reference model advances on the rising edge and compares all outputs on the next falling edge, so each comparison lands in the first cycle the result is due. Directed checks sample at that same half-cycle point.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_REF  = 2'd2,
    ST_COL  = 2'd3
  } dcc_state_e;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_PINS = 2'd1,
    RK_CBR  = 2'd2,
    RK_WCBR = 2'd3
  } ref_kind_e;
endpackage

// File: rtl/dcc_edge_det.sv
module dcc_edge_det #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_fall
    assign fall_o[g] = prev_q[g] & ~lvl_i[g];
  end
endmodule

// File: rtl/dcc_ref_ctr.sv
module dcc_ref_ctr #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [AW-1:0] cnt_o
);
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // counter steps by one per counter refresh, wrapping at full scale
  assert_ctr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_o == AW'($past(cnt_o) + 1'b1));
endmodule

// File: rtl/dcc_cell_array.sv
module dcc_cell_array #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  parameter int DW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             we_i,
  input  logic             pair_i,
  input  logic [DW-1:0]    din_i,
  output logic [DW-1:0]    rd_o
);
  localparam int WORDS = 1 << (ROW_W + COL_W);
  localparam int IW    = ROW_W + COL_W;

  logic [DW-1:0]    mem_q [WORDS];
  logic [COL_W-1:0] col_ev, col_od;
  logic [IW-1:0]    idx, idx_ev, idx_od;
  logic [DW-1:0]    w_ev, w_od, cmp;

  assign col_ev = col_i & ~COL_W'(1);
  assign col_od = col_i |  COL_W'(1);
  assign idx    = {row_i, col_i};
  assign idx_ev = {row_i, col_ev};
  assign idx_od = {row_i, col_od};
  assign w_ev   = mem_q[idx_ev];
  assign w_od   = mem_q[idx_od];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      if (pair_i) begin
        mem_q[idx_ev] <= din_i;
        mem_q[idx_od] <= din_i;
      end else begin
        mem_q[idx] <= din_i;
      end
    end
  end

  // per-bit agreement of the column pair
  for (genvar b = 0; b < DW; b++) begin : g_cmp
    assign cmp[b] = ~(w_ev[b] ^ w_od[b]);
  end

  assign rd_o = pair_i ? cmp : mem_q[idx];
endmodule

// File: rtl/dcc_seq.sv
module dcc_seq
  import dcc_pkg::*;
#(
  parameter int AW    = 10,
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  parameter int DW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_fall_i,
  input  logic             cas_fall_i,
  input  logic             we_fall_i,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic             oe_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [AW-1:0]    cnt_i,
  input  logic [DW-1:0]    rd_i,
  output logic             cnt_inc_o,
  output logic [ROW_W-1:0] mem_row_o,
  output logic [COL_W-1:0] mem_col_o,
  output logic             mem_we_o,
  output logic             test_mode_o,
  output logic [DW-1:0]    dout_o,
  output logic             dout_en_o,
  output logic             ref_pulse_o,
  output logic [AW-1:0]    ref_row_o,
  output logic [1:0]       ref_kind_o
);
  dcc_state_e       state_q, state_d;
  ref_kind_e        kind_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             early_q, early_d;
  logic             tm_q, tm_d;
  logic [DW-1:0]    rd_q, rd_d;
  logic [DW-1:0]    dout_q;
  logic             en_q, en_d;
  logic             pulse_q;
  logic [AW-1:0]    ref_row_q;

  logic ras_rise, row_open, col_strobe, rmw_strobe, cbr;

  // ras can only rise from a non-idle state
  assign ras_rise   = ras_ni && (state_q != ST_IDLE);
  assign row_open   = (state_q == ST_ROW) || (state_q == ST_COL);
  assign col_strobe = row_open && !ras_rise && cas_fall_i;
  assign rmw_strobe = (state_q == ST_COL) && !ras_rise && !cas_ni && !cas_fall_i
                      && we_fall_i && !early_q;
  assign cbr        = ras_fall_i && !cas_ni;

  always_comb begin
    state_d = state_q;
    if (ras_fall_i)      state_d = cbr ? ST_REF : ST_ROW;
    else if (ras_rise)   state_d = ST_IDLE;
    else if (col_strobe) state_d = ST_COL;
  end

  always_comb begin
    tm_d = tm_q;
    if (cbr)                                tm_d = !we_ni;
    else if (ras_rise && state_q == ST_ROW) tm_d = 1'b0;
  end

  assign early_d = col_strobe ? !we_ni : early_q;
  assign rd_d    = (col_strobe && we_ni) ? rd_i : rd_q;
  assign en_d    = (state_d == ST_COL) && !cas_ni && !oe_ni && !early_d;

  assign mem_we_o  = (col_strobe && !we_ni) || rmw_strobe;
  assign mem_col_o = col_strobe ? addr_i[COL_W-1:0] : col_q;
  assign mem_row_o = row_q;
  assign cnt_inc_o = cbr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= RK_NONE;
      row_q     <= '0;
      col_q     <= '0;
      early_q   <= 1'b0;
      tm_q      <= 1'b0;
      rd_q      <= '0;
      dout_q    <= '0;
      en_q      <= 1'b0;
      pulse_q   <= 1'b0;
      ref_row_q <= '0;
    end else begin
      state_q <= state_d;
      early_q <= early_d;
      tm_q    <= tm_d;
      rd_q    <= rd_d;
      en_q    <= en_d;
      dout_q  <= en_d ? rd_d : '0;
      pulse_q <= ras_fall_i;
      if (col_strobe) col_q <= addr_i[COL_W-1:0];
      if (ras_fall_i) begin
        if (cbr) begin
          ref_row_q <= cnt_i;
          kind_q    <= we_ni ? RK_CBR : RK_WCBR;
        end else begin
          ref_row_q <= addr_i;
          kind_q    <= RK_PINS;
          row_q     <= addr_i[ROW_W-1:0];
        end
      end
    end
  end

  assign test_mode_o = tm_q;
  assign dout_o      = dout_q;
  assign dout_en_o   = en_q;
  assign ref_pulse_o = pulse_q;
  assign ref_row_o   = ref_row_q;
  assign ref_kind_o  = kind_q;

  assert_early_no_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_strobe && !we_ni) |=> !dout_en_o);

  assert_tm_enter_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall_i && !cas_ni && !we_ni) |=> test_mode_o);

  assert_tm_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tm_q) |-> ($past(cbr) || $past(ras_rise && state_q == ST_ROW)));

  assert_ref_no_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REF) |-> !dout_en_o);

  assert_strobe_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_ni || oe_ni) |=> !dout_en_o);

  assert_quiet_bus_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_en_o |-> dout_o == '0);

  assert_pulse_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |=> !ref_pulse_o);
endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl #(
  parameter int AW    = 10,
  parameter int DW    = 4,
  parameter int ROW_W = 3,
  parameter int COL_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o,
  output logic          test_mode_o,
  output logic          ref_pulse_o,
  output logic [AW-1:0] ref_row_o,
  output logic [1:0]    ref_kind_o
);
  localparam int NSTB = 3;

  logic [NSTB-1:0]  stb_fall;
  logic [AW-1:0]    cnt;
  logic             cnt_inc;
  logic [ROW_W-1:0] mem_row;
  logic [COL_W-1:0] mem_col;
  logic             mem_we;
  logic [DW-1:0]    rd;
  logic             tm;

  dcc_edge_det #(.N(NSTB)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({we_ni, cas_ni, ras_ni}),
    .fall_o (stb_fall)
  );

  dcc_ref_ctr #(.AW(AW)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  dcc_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .row_i  (mem_row),
    .col_i  (mem_col),
    .we_i   (mem_we),
    .pair_i (tm),
    .din_i  (din_i),
    .rd_o   (rd)
  );

  dcc_seq #(.AW(AW), .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ras_fall_i  (stb_fall[0]),
    .cas_fall_i  (stb_fall[1]),
    .we_fall_i   (stb_fall[2]),
    .ras_ni      (ras_ni),
    .cas_ni      (cas_ni),
    .we_ni       (we_ni),
    .oe_ni       (oe_ni),
    .addr_i      (addr_i),
    .cnt_i       (cnt),
    .rd_i        (rd),
    .cnt_inc_o   (cnt_inc),
    .mem_row_o   (mem_row),
    .mem_col_o   (mem_col),
    .mem_we_o    (mem_we),
    .test_mode_o (tm),
    .dout_o      (dout_o),
    .dout_en_o   (dout_en_o),
    .ref_pulse_o (ref_pulse_o),
    .ref_row_o   (ref_row_o),
    .ref_kind_o  (ref_kind_o)
  );

  assign test_mode_o = tm;
endmodule

// File: tb/dram_cycle_ctrl_bench.sv
module dram_cycle_ctrl_bench;
  localparam int AW = 10;
  localparam int DW = 4;
  localparam int NCOL = 8;
  localparam int NWORD = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, tmode, rpulse;
  logic [AW-1:0] rrow;
  logic [1:0] rkind;

  int vecs = 0, fails = 0, ncbr = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  dram_cycle_ctrl u_dram_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .din_i(din), .dout_o(dout), .dout_en_o(dout_en),
    .test_mode_o(tmode), .ref_pulse_o(rpulse), .ref_row_o(rrow), .ref_kind_o(rkind)
  );

  // behavioural reference model
  int  m [NWORD];
  bit  p_r, p_c, p_w, m_early, m_tm;
  int  mode, m_row, m_col, m_rd, m_ctr;
  bit  e_en, e_pulse;
  int  e_dout, e_row, e_kind;

  function automatic int rd_model();
    int a, b;
    a = m[m_row*NCOL + (m_col & ~1)];
    b = m[m_row*NCOL + (m_col | 1)];
    if (m_tm) return (~(a ^ b)) & 15;
    return m[m_row*NCOL + m_col];
  endfunction

  task automatic wr_model(int d);
    if (m_tm) begin
      m[m_row*NCOL + (m_col & ~1)] = d;
      m[m_row*NCOL + (m_col | 1)]  = d;
    end else m[m_row*NCOL + m_col] = d;
  endtask

  always @(posedge clk or negedge rst_n) begin
    bit rf, rr, cf, wf;
    if (!rst_n) begin
      foreach (m[i]) m[i] = 0;
      p_r = 1; p_c = 1; p_w = 1; m_early = 0; m_tm = 0;
      mode = 0; m_row = 0; m_col = 0; m_rd = 0; m_ctr = 0;
      e_en = 0; e_pulse = 0; e_dout = 0; e_row = 0; e_kind = 0;
    end else begin
      rf = p_r && !ras_n; rr = !p_r && ras_n;
      cf = p_c && !cas_n; wf = p_w && !we_n;
      e_pulse = 0;
      if (rf) begin
        e_pulse = 1;
        if (!cas_n) begin
          e_row = m_ctr; e_kind = we_n ? 2 : 3;
          m_ctr = (m_ctr + 1) % 1024; m_tm = !we_n; mode = 2;
        end else begin
          e_row = addr; e_kind = 1; m_row = addr % 8; mode = 1;
        end
      end else if (rr) begin
        if (mode == 1) m_tm = 0;
        mode = 0;
      end else if ((mode == 1 || mode == 3) && cf) begin
        mode = 3; m_col = addr % 8; m_early = !we_n;
        if (!we_n) wr_model(din); else m_rd = rd_model();
      end else if (mode == 3 && !cas_n && wf && !m_early) begin
        wr_model(din);
      end
      e_en = (mode == 3) && !cas_n && !oe_n && !m_early;
      e_dout = e_en ? m_rd : 0;
      p_r = ras_n; p_c = cas_n; p_w = we_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vecs++;
      if (dout_en !== e_en || dout !== DW'(e_dout) || tmode !== m_tm ||
          rpulse !== e_pulse || rrow !== AW'(e_row) || rkind !== 2'(e_kind)) begin
        fails++;
        $display("FAIL %s model: got en=%b d=%h tm=%b p=%b row=%0d k=%0d exp en=%b d=%h tm=%b p=%b row=%0d k=%0d",
                 cur_req, dout_en, dout, tmode, rpulse, rrow, rkind,
                 e_en, e_dout[3:0], m_tm, e_pulse, e_row, e_kind);
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, got, exp);
    end
  endtask

  task automatic row_open(int a);
    @(negedge clk); addr = AW'(a); ras_n = 0;
  endtask

  task automatic col(int a, bit wr, int d);
    @(negedge clk); addr = AW'(a); din = DW'(d); we_n = !wr; oe_n = wr; cas_n = 0;
  endtask

  task automatic row_close();
    @(negedge clk); cas_n = 1; we_n = 1; oe_n = 1;
    @(negedge clk); ras_n = 1;
    @(negedge clk);
  endtask

  task automatic write_word(int r, int c, int d);
    row_open(r); col(c, 1, d);
    @(negedge clk); chk("R7", "early write enable", dout_en, 0);
    row_close();
  endtask

  task automatic read_word(string req, int r, int c, int exp);
    row_open(r); col(c, 0, 0);
    @(negedge clk);
    chk(req, "read enable", dout_en, 1);
    chk(req, "read data", dout, exp);
    cas_n = 1; oe_n = 1;
    @(negedge clk); chk("R9", "off after cas rise", dout_en, 0);
    ras_n = 1;
    @(negedge clk);
  endtask

  task automatic cbr(bit wlow);
    @(negedge clk); cas_n = 0; we_n = !wlow;
    @(negedge clk); ras_n = 0;
    @(negedge clk);
    chk(wlow ? "R4" : "R3", "cbr pulse", rpulse, 1);
    chk(wlow ? "R4" : "R3", "cbr row", rrow, ncbr % 1024);
    chk(wlow ? "R4" : "R3", "cbr kind", rkind, wlow ? 3 : 2);
    ncbr++;
    ras_n = 1;
    @(negedge clk); cas_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic ras_only(int a);
    row_open(a);
    @(negedge clk);
    chk("R2", "pin pulse", rpulse, 1);
    chk("R2", "pin row", rrow, a);
    chk("R2", "pin kind", rkind, 1);
    chk("R2", "no drive", dout_en, 0);
    chk("R12", "quiet bus", dout, 0);
    ras_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", "reset enable", dout_en, 0);
    chk("R1", "reset data", dout, 0);
    chk("R1", "reset test", tmode, 0);
    chk("R1", "reset pulse", rpulse, 0);
    chk("R1", "reset kind", rkind, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    cur_req = "R6";
    write_word(1, 2, 'hA);
    write_word(1, 3, 'h3);
    read_word("R6", 1, 2, 'hA);
    read_word("R6", 1, 3, 'h3);

    cur_req = "R9";
    row_open(1); col(2, 0, 0);
    @(negedge clk); chk("R9", "on before oe", dout_en, 1);
    oe_n = 1;
    @(negedge clk); chk("R9", "off after oe high", dout_en, 0);
    oe_n = 0;
    @(negedge clk); chk("R9", "on again", dout_en, 1);
    row_close();

    cur_req = "R8";
    row_open(1); col(2, 0, 0);
    @(negedge clk); chk("R8", "rmw read", dout, 'hA);
    din = 4'h6; we_n = 0;
    @(negedge clk); chk("R8", "rmw old data held", dout, 'hA);
    chk("R8", "rmw enable", dout_en, 1);
    row_close();
    read_word("R8", 1, 2, 'h6);

    cur_req = "R11";
    row_open(2);
    col(1, 1, 'h7); @(negedge clk); cas_n = 1; we_n = 1; oe_n = 1;
    col(2, 1, 'h9); @(negedge clk); cas_n = 1; we_n = 1; oe_n = 1;
    col(1, 0, 0); @(negedge clk); chk("R11", "page col1", dout, 'h7);
    cas_n = 1; oe_n = 1;
    col(2, 0, 0); @(negedge clk); chk("R11", "page col2", dout, 'h9);
    row_close();

    cur_req = "R2";
    ras_only('h155);

    cur_req = "R3";
    cbr(0);
    cbr(0);

    cur_req = "R10";
    write_word(4, 2, 'hC);
    write_word(4, 3, 'hA);
    cur_req = "R4";
    cbr(1);
    chk("R4", "test flag set", tmode, 1);
    cur_req = "R10";
    read_word("R10", 4, 2, 'h9);
    chk("R5", "test kept after read", tmode, 1);
    write_word(4, 4, 'h5);
    chk("R5", "test kept after write", tmode, 1);
    cur_req = "R5";
    ras_only(7);
    chk("R5", "test cleared by pin refresh", tmode, 0);
    read_word("R10", 4, 4, 'h5);
    read_word("R10", 4, 5, 'h5);

    cbr(1);
    chk("R5", "test set again", tmode, 1);
    cbr(0);
    chk("R5", "test cleared by counter refresh", tmode, 0);

    cur_req = "R3";
    while (ncbr <= 1024) cbr(0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL %s watchdog: got timeout exp completion", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule